// File: doc/BRIEF.md
# NEC Infrared Frame Transmitter

This block draws the envelope of an NEC-style infrared remote-control frame on one output pin. It sends no carrier. All durations are counted in ticks of a divided clock, normally 1 µs. A divider of `TICK_DIV` core cycles makes each tick. The leader mark and space, the short-repeat space, the bit-cell mark, the zero and one spaces, the frame period, the repeat count, the repeat style and the two polarity controls are all configuration inputs. The block samples them at the moment a transmission starts.

A rising edge on `tx_en` starts a transmission. The block sends a full frame first. It then sends `repeat_cnt` more frames, each starting `frame_period` ticks after the previous one. A repeat is either the short repeat code or the whole frame sent again. When the last frame has finished, a sticky end flag is raised. Lowering `tx_en` aborts at once.

Top module: `nec_ir_tx`

## Requirements
- R1: A transmission starts only on the cycle where `tx_en` is sampled high after being low while the block is idle. From then on `busy` is 1, and the leader mark begins on the next cycle. If `tx_en` stays high after completion, nothing restarts.
- R2: Each tick lasts `TICK_DIV` clock cycles. A frame opens with a leader mark of `lead_mark_len` ticks, followed by a leader space of `lead_space_len` ticks.
- R3: Each data bit is a mark of `bit_mark_len` ticks followed by a space. The space lasts `zero_space_len` ticks for a 0 and `one_space_len` ticks for a 1.
- R4: The 32-bit payload is sent byte by byte in the order bits [31:24], [23:16], [15:8], [7:0]. Within each byte the LSB goes first.
- R5: Every frame and every short repeat code ends with a trailing mark of `bit_mark_len` ticks. The line then stays at the space level.
- R6: After the first frame, exactly `repeat_cnt` further frames are sent. Each one starts `frame_period` ticks after the start of the previous one.
- R7: With `fmt` = 1, each repeat is the complete frame. With any other `fmt` value, a repeat is the short code: a leader mark, a space of `rpt_space_len` ticks, and then the trailing mark.
- R8: When the block is not busy, `ir_out` equals `idle_level`. While busy, marks drive 1 and spaces drive 0. Setting `act_invert` swaps these two levels.
- R9: Lowering `tx_en` returns the block to idle on the next edge: `busy` goes to 0, `ir_out` goes to the idle level, and the end flag is not raised.
- R10: `end_irq` is set on the edge where the trailing mark of the last frame ends. It stays set until `irq_clr` is pulsed. If setting and clearing happen in the same cycle, setting wins.
- R11: Configuration inputs that change while a transmission is running have no effect on it.
- R12: After reset, `busy` and `end_irq` are 0 and `ir_out` equals `idle_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Start on a rising edge; low aborts |
| irq_clr | input | 1 | Clears the end flag |
| lead_mark_len | input | SEG_W | Leader mark length, in ticks |
| lead_space_len | input | SEG_W | Leader space length for a full frame |
| rpt_space_len | input | SEG_W | Leader space length for a short repeat |
| bit_mark_len | input | SEG_W | Bit-cell and trailing mark length |
| zero_space_len | input | SEG_W | Space length for a 0 bit |
| one_space_len | input | SEG_W | Space length for a 1 bit |
| payload | input | 32 | Address, ~address, command, ~command |
| frame_period | input | FRM_W | Ticks from one frame start to the next (at least 1) |
| repeat_cnt | input | RPT_W | Number of frames after the first |
| fmt | input | 4 | Repeat style; 1 = full frame |
| idle_level | input | 1 | Output level while not busy |
| act_invert | input | 1 | Swaps the mark and space levels |
| ir_out | output | 1 | Infrared envelope |
| busy | output | 1 | A transmission is running |
| end_irq | output | 1 | Sticky end-of-transmission flag |

## Verification
The bench builds the block with `TICK_DIV` = 2. Every tick then spans two cycles, which brings the exact cycle of each boundary between segments within reach. The bench samples each tick in its middle and compares the result with a waveform it builds itself. The segment widths are kept at a few ticks and the frame period at 140 ticks. With these values, multi-frame runs in both repeat styles, inverted polarity, an abort in the middle of a frame, and a change of configuration during a run all fit within a few hundred ticks per case.

// File: rtl/nec_ir_tx.sv
module nec_ir_tx #(
  parameter int TICK_DIV = 100,
  parameter int SEG_W    = 16,
  parameter int FRM_W    = 18,
  parameter int RPT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             irq_clr,
  input  logic [SEG_W-1:0] lead_mark_len,
  input  logic [SEG_W-1:0] lead_space_len,
  input  logic [SEG_W-1:0] rpt_space_len,
  input  logic [SEG_W-1:0] bit_mark_len,
  input  logic [SEG_W-1:0] zero_space_len,
  input  logic [SEG_W-1:0] one_space_len,
  input  logic [31:0]      payload,
  input  logic [FRM_W-1:0] frame_period,
  input  logic [RPT_W-1:0] repeat_cnt,
  input  logic [3:0]       fmt,
  input  logic             idle_level,
  input  logic             act_invert,
  output logic             ir_out,
  output logic             busy,
  output logic             end_irq
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_LMARK, S_LSPACE, S_BMARK, S_BSPACE, S_TMARK, S_GAP, S_DONE} st_t;

  st_t              st;
  logic             en_q;
  logic [DIV_W-1:0] div;
  logic [SEG_W-1:0] seg;
  logic [FRM_W-1:0] ftm;
  logic [RPT_W-1:0] rleft;
  logic [4:0]       bidx;
  logic             is_rpt;

  logic [SEG_W-1:0] c_lmark, c_lspace, c_rspace, c_bmark, c_zero, c_one;
  logic [31:0]      c_data;
  logic [FRM_W-1:0] c_period;
  logic             c_full, c_inv;

  logic tick, seg_done, frm_end, next_frame, is_mark, cur_bit, short_rpt;

  assign tick       = (div == DIV_W'(TICK_DIV - 1));
  assign seg_done   = tick && (seg <= SEG_W'(1));
  assign frm_end    = tick && (ftm == c_period - FRM_W'(1));
  assign next_frame = frm_end && (rleft != '0);
  assign short_rpt  = is_rpt && !c_full;
  assign cur_bit    = c_data[{~bidx[4:3], bidx[2:0]}];
  assign is_mark    = (st == S_LMARK) || (st == S_BMARK) || (st == S_TMARK);
  assign busy       = (st != S_IDLE) && (st != S_DONE);
  assign ir_out     = busy ? (is_mark ^ c_inv) : idle_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; en_q <= 1'b0; div <= '0; seg <= '0; ftm <= '0;
      rleft <= '0; bidx <= '0; is_rpt <= 1'b0; end_irq <= 1'b0;
      c_lmark <= '0; c_lspace <= '0; c_rspace <= '0; c_bmark <= '0;
      c_zero <= '0; c_one <= '0; c_data <= '0; c_period <= '0;
      c_full <= 1'b0; c_inv <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (irq_clr) end_irq <= 1'b0;
      if (!tx_en) begin
        st <= S_IDLE;
      end else if (st == S_IDLE) begin
        if (!en_q) begin
          c_lmark <= lead_mark_len; c_lspace <= lead_space_len; c_rspace <= rpt_space_len;
          c_bmark <= bit_mark_len; c_zero <= zero_space_len; c_one <= one_space_len;
          c_data <= payload; c_period <= frame_period; c_full <= (fmt == 4'd1);
          c_inv <= act_invert;
          div <= '0; ftm <= '0; seg <= lead_mark_len; rleft <= repeat_cnt;
          bidx <= '0; is_rpt <= 1'b0; st <= S_LMARK;
        end
      end else if (st != S_DONE) begin
        div <= tick ? '0 : div + DIV_W'(1);
        if (tick) ftm <= frm_end ? '0 : ftm + FRM_W'(1);
        if (tick && !seg_done) seg <= seg - SEG_W'(1);
        if (next_frame) begin
          st <= S_LMARK; seg <= c_lmark; rleft <= rleft - RPT_W'(1);
          is_rpt <= 1'b1; bidx <= '0;
        end else if (seg_done) begin
          case (st)
            S_LMARK: begin
              st  <= S_LSPACE;
              seg <= short_rpt ? c_rspace : c_lspace;
            end
            S_LSPACE: begin
              st  <= short_rpt ? S_TMARK : S_BMARK;
              seg <= c_bmark;
            end
            S_BMARK: begin
              st  <= S_BSPACE;
              seg <= cur_bit ? c_one : c_zero;
            end
            S_BSPACE: begin
              st   <= (bidx == 5'd31) ? S_TMARK : S_BMARK;
              seg  <= c_bmark;
              bidx <= bidx + 5'd1;
            end
            S_TMARK: begin
              if (rleft == '0) begin
                st <= S_DONE;
                end_irq <= 1'b1;
              end else begin
                st <= S_GAP;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r9_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!busy && ir_out == idle_level));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (end_irq && !irq_clr) |=> end_irq);

  a_r10_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && st != S_TMARK) |=> !end_irq);

  a_r10_set_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_irq) |-> ($past(busy) && !busy));

  a_r2_tick_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(tick)) |-> $stable(ir_out));

  a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && tx_en) |=> !busy);
endmodule

// File: tb/tb_nec_ir_tx.sv
`timescale 1ns/1ps
module tb_nec_ir_tx;
  localparam int TD = 2, SW = 16, FW = 18, RW = 16;
  localparam int LA = 4, LI = 2, RI = 1, BA = 1, ZS = 1, OS = 3, PER = 140;

  typedef struct packed {
    logic [31:0] data; logic [3:0] fmt; logic [15:0] rpt;
    logic inv; logic idle; logic [15:0] endt;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{32'h00FF00FF, 4'd0, 16'd0, 1'b0, 1'b0, 16'd103},
    '{32'h5AA53CC3, 4'd0, 16'd2, 1'b0, 1'b0, 16'd286},
    '{32'h817E42BD, 4'd1, 16'd1, 1'b0, 1'b0, 16'd243},
    '{32'h00000000, 4'd3, 16'd1, 1'b1, 1'b1, 16'd146}
  };

  logic clk = 0, rst_n = 0, tx_en = 0, irq_clr = 0;
  logic [SW-1:0] la, li, ri, ba, zs, os;
  logic [31:0] data;
  logic [FW-1:0] per;
  logic [RW-1:0] rpt;
  logic [3:0] fmt;
  logic idle_level = 0, act_invert = 0;
  logic ir_out, busy, end_irq;
  int checks = 0, fails = 0;
  logic [511:0] lvl;

  always #4 clk = ~clk;

  nec_ir_tx #(.TICK_DIV(TD), .SEG_W(SW), .FRM_W(FW), .RPT_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_clr(irq_clr),
    .lead_mark_len(la), .lead_space_len(li), .rpt_space_len(ri),
    .bit_mark_len(ba), .zero_space_len(zs), .one_space_len(os),
    .payload(data), .frame_period(per), .repeat_cnt(rpt), .fmt(fmt),
    .idle_level(idle_level), .act_invert(act_invert),
    .ir_out(ir_out), .busy(busy), .end_irq(end_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mark(inout int p, input int len);
    for (int j = 0; j < len; j++) lvl[p + j] = 1'b1;
    p += len;
  endtask

  task automatic build(input vec_t v);
    lvl = '0;
    for (int f = 0; f <= int'(v.rpt); f++) begin
      int p = f * PER;
      bit full = (f == 0) || (v.fmt == 4'd1);
      mark(p, LA);
      p += full ? LI : RI;
      if (full)
        for (int b = 3; b >= 0; b--)
          for (int i = 0; i < 8; i++) begin
            mark(p, BA);
            p += v.data[b*8 + i] ? OS : ZS;
          end
      mark(p, BA);
    end
  endtask

  task automatic load(input vec_t v);
    la = LA; li = LI; ri = RI; ba = BA; zs = ZS; os = OS; per = PER;
    data = v.data; fmt = v.fmt; rpt = v.rpt; act_invert = v.inv; idle_level = v.idle;
  endtask

  task automatic run_case(input vec_t v, input bit mutate, input bit abort);
    int bad_t = -1, bad_a = 0, bad_e = 0;
    load(v);
    build(v);
    tx_en = 0;
    @(negedge clk); tx_en = 1;
    @(posedge clk); @(negedge clk);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    for (int t = 0; t < int'(v.endt); t++) begin
      if (mutate && t == 1) begin
        la = 9; li = 9; ba = 5; zs = 7; os = 2; data = ~data; per = 50;
        rpt = 16'd7; fmt = ~fmt; act_invert = ~act_invert;
      end
      if (abort && t == 20) begin
        tx_en = 0;
        @(negedge clk);
        chk(!busy && ir_out == idle_level, "R9 abort to idle", {busy, ir_out}, {1'b0, idle_level});
        repeat (600) @(negedge clk);
        chk(end_irq == 1'b0, "R9 no end flag after abort", end_irq, 0);
        return;
      end
      if (bad_t < 0 && (ir_out !== (lvl[t] ^ v.inv) || busy !== 1'b1)) begin
        bad_t = t; bad_a = {busy, ir_out}; bad_e = {1'b1, lvl[t] ^ v.inv};
      end
      repeat (2) @(negedge clk);
    end
    chk(bad_t < 0, mutate ? "R11 waveform unchanged by late writes" :
        "R2/R3/R4/R5/R6/R7/R8 waveform", bad_a, bad_e);
    if (bad_t >= 0) $display("  first mismatch at tick %0d", bad_t);
    chk(!busy && end_irq && ir_out == idle_level, "R10 end flag at finish",
        {busy, end_irq, ir_out}, {1'b0, 1'b1, idle_level});
    repeat (2 * PER) @(negedge clk);
    chk(!busy, "R1 no restart while held high", busy, 0);
    chk(end_irq, "R10 flag sticky", end_irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(!end_irq, "R10 cleared by pulse", end_irq, 0);
    tx_en = 0; @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    load(VEC[0]);
    repeat (3) @(negedge clk);
    chk(!busy && !end_irq && ir_out == 1'b0, "R12 reset state",
        {busy, end_irq, ir_out}, 0);
    rst_n = 1;
    @(negedge clk);
    idle_level = 1; @(negedge clk);
    chk(ir_out == 1'b1, "R8 idle level follows input", ir_out, 1);
    idle_level = 0; @(negedge clk);
    chk(ir_out == 1'b0, "R8 idle level low", ir_out, 0);
    for (int k = 0; k < 4; k++) run_case(VEC[k], 1'b0, 1'b0);
    run_case(VEC[0], 1'b1, 1'b0);
    run_case(VEC[1], 1'b0, 1'b1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule